// File: doc/BRIEF.md
# Interrupt Redirection Message Dispatcher

This block watches a set of interrupt input lines and turns each new assertion into one or more interrupt messages for the processor-side interrupt controllers. Every line has a redirection entry, supplied as a static input word by the surrounding register logic. The entry says whether the line is masked, which vector and delivery mode to use, and where the message goes.

A rising edge on a line marks it pending. The dispatcher serves one pending line at a time, lowest number first. It reads that line's entry, drops the event if the entry is masked or unusable, and otherwise places a message on a valid/ready output. In logical destination mode the 8-bit destination is a bitmap, and the block sends one unicast message for each set bit. For the external-interrupt delivery mode, the vector is not taken from the entry. The block fetches it from an outside legacy controller through a request/response handshake.

Top module: `irq_redirect_dispatch`

## Requirements
- R1: An event on a line whose entry has mask bit 14 set produces no message and no error, and it consumes the pending state. Unmasking the entry later while the line stays high sends nothing.
- R2: Each message copies delivery mode (entry bits [10:8]), destination mode (bit 11) and trigger (bit 13) from the entry. The message level field carries the entry polarity (bit 12).
- R3: For every delivery mode other than 7, the message vector is the entry's vector field (bits [7:0]).
- R4: With delivery mode 7, `ext_req_o` pulses high for exactly one cycle. No message appears until `ext_vld_i` is seen, and the message vector is the `ext_vector_i` value sampled with it.
- R5: Delivery modes 3 and 6 are reserved. An unmasked entry with either code sends no message and raises `err_o` for exactly one cycle.
- R6: With destination mode 0, exactly one message is sent, and its destination is the entry destination field (bits [22:15]).
- R7: With destination mode 1, one message is sent for each set bit of the destination field, in ascending bit order. Each message's destination equals the index of its bit.
- R8: A line becomes pending on a rising edge only. Holding a line high after it has been served produces no further messages.
- R9: When several lines are pending, the lowest-numbered line is served completely before any other line.
- R10: While `msg_valid_o` is high and `msg_ready_i` is low, every message output holds stable. A logical-mode burst moves to the next bit only after the current message is accepted.
- R11: Destination mode 1 with an all-zero destination field sends no message and raises no error.
- R12: During reset, `msg_valid_o`, `ext_req_o` and `err_o` are low.

Line g's entry occupies `table_i[g*23 +: 23]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | NUM_LINES | Interrupt input lines, rising-edge sensed |
| table_i | input | NUM_LINES*23 | Redirection entries, one 23-bit entry per line |
| msg_ready_i | input | 1 | Receiver accepts the current message |
| ext_vld_i | input | 1 | External controller vector response strobe |
| ext_vector_i | input | 8 | Vector returned by the external controller |
| msg_valid_o | output | 1 | Message present on the output |
| msg_dest_o | output | 8 | Destination identifier |
| msg_vector_o | output | 8 | Interrupt vector |
| msg_mode_o | output | 3 | Delivery mode |
| msg_dest_mode_o | output | 1 | Destination mode (0 physical, 1 logical) |
| msg_level_o | output | 1 | Level field (entry polarity) |
| msg_trigger_o | output | 1 | Trigger mode |
| ext_req_o | output | 1 | One-cycle request for an external vector |
| err_o | output | 1 | One-cycle pulse on a reserved delivery mode |

## Verification
A vector table drives a single line through physical and logical entries. The logical entries use sparse, single-bit, full and empty bitmaps, which separates burst ordering from burst termination. The table also covers the fixed and NMI modes (vector taken from the entry) and the external mode in both destination modes (vector fetched from outside). Masked, reserved and masked-reserved entries confirm that masking wins over the error indication. Directed tests stall the receiver in the middle of a burst, raise two lines together to check that service is ordered, hold lines high to show that only edges count, and unmask an entry after its event was dropped.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   localparam int VEC_W  = 8;
   localparam int DEST_W = 8;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      DM_FIXED  = 3'd0,
      DM_LOWPRI = 3'd1,
      DM_SMI    = 3'd2,
      DM_RSVD_A = 3'd3,
      DM_NMI    = 3'd4,
      DM_INIT   = 3'd5,
      DM_RSVD_B = 3'd6,
      DM_EXTERN = 3'd7
   } dmode_e;

   typedef struct packed {
      logic [DEST_W-1:0] dest;
      logic              mask;
      logic              trigger;
      logic              polarity;
      logic              dest_mode;
      dmode_e            mode;
      logic [VEC_W-1:0]  vector;
   } redir_t;

   localparam int ENTRY_W = $bits(redir_t);

   function automatic logic mode_reserved(dmode_e m);
      return (m == DM_RSVD_A) || (m == DM_RSVD_B);
   endfunction
endpackage

// File: rtl/irqd_pending.sv
module irqd_pending #(
   parameter int NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines_i,
   input  logic [NUM_LINES-1:0] clear_i,
   output logic [NUM_LINES-1:0] pend_o
);
   logic [NUM_LINES-1:0] prev_q;
   logic [NUM_LINES-1:0] rise;

   assign rise = lines_i & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_o <= '0;
      end else begin
         prev_q <= lines_i;
         pend_o <= (pend_o & ~clear_i) | rise;
      end
   end

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
      // R8: an edge always leaves the line pending
      a_r8_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
         rise[g] |=> pend_o[g]);
      // R8: pending survives until the dispatcher clears it
      a_r8_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
         pend_o[g] && !clear_i[g] |=> pend_o[g]);
   end
endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
   parameter int NUM_LINES = 8,
   localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic [NUM_LINES-1:0] req_i,
   output logic                 any_o,
   output logic [IDX_W-1:0]     idx_o
);
   assign any_o = |req_i;

   if (NUM_LINES == 1) begin : g_single
      assign idx_o = '0;
   end else begin : g_multi
      always_comb begin
         idx_o = '0;
         for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = i[IDX_W-1:0];
         end
      end
   end
endmodule

// File: rtl/irqd_dispatch.sv
module irqd_dispatch
   import irqd_pkg::*;
#(
   parameter int NUM_LINES = 8,
   localparam int IDX_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
   localparam int LIDX_W = $clog2(DEST_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 any_i,
   input  logic [IDX_W-1:0]     idx_i,
   input  redir_t               entry_i,
   input  logic                 msg_ready_i,
   input  logic                 ext_vld_i,
   input  logic [VEC_W-1:0]     ext_vector_i,
   output logic [NUM_LINES-1:0] clear_o,
   output logic                 msg_valid_o,
   output logic [DEST_W-1:0]    msg_dest_o,
   output logic [VEC_W-1:0]     msg_vector_o,
   output logic [MODE_W-1:0]    msg_mode_o,
   output logic                 msg_dest_mode_o,
   output logic                 msg_level_o,
   output logic                 msg_trigger_o,
   output logic                 ext_req_o,
   output logic                 err_o
);
   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SEND} st_e;

   st_e               state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DEST_W-1:0] dest_q;
   logic [DEST_W-1:0] rem_q;
   logic [VEC_W-1:0]  vec_q;
   dmode_e            mode_q;
   logic              dm_q, pol_q, trig_q;
   logic              req_q, err_q;

   logic              drop, drop_err, accept, burst_done;
   logic [DEST_W-1:0] rem_nxt;
   logic [LIDX_W-1:0] low_idx;

   assign drop     = entry_i.mask || mode_reserved(entry_i.mode) ||
                     (entry_i.dest_mode && (entry_i.dest == '0));
   assign drop_err = !entry_i.mask && mode_reserved(entry_i.mode);

   always_comb begin
      low_idx = '0;
      for (int i = DEST_W - 1; i >= 0; i--) begin
         if (rem_q[i]) low_idx = i[LIDX_W-1:0];
      end
   end

   assign rem_nxt    = rem_q & (rem_q - 1'b1);
   assign accept     = (state_q == ST_SEND) && msg_ready_i;
   assign burst_done = accept && (!dm_q || (rem_nxt == '0));

   always_comb begin
      for (int i = 0; i < NUM_LINES; i++) begin
         clear_o[i] = ((state_q == ST_IDLE) && any_i && drop && (idx_i == i[IDX_W-1:0])) ||
                      (burst_done && (idx_q == i[IDX_W-1:0]));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         dest_q  <= '0;
         rem_q   <= '0;
         vec_q   <= '0;
         mode_q  <= DM_FIXED;
         dm_q    <= 1'b0;
         pol_q   <= 1'b0;
         trig_q  <= 1'b0;
         req_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         req_q <= 1'b0;
         err_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (any_i) begin
                  if (drop) begin
                     err_q <= drop_err;
                  end else begin
                     idx_q  <= idx_i;
                     dest_q <= entry_i.dest;
                     rem_q  <= entry_i.dest;
                     vec_q  <= entry_i.vector;
                     mode_q <= entry_i.mode;
                     dm_q   <= entry_i.dest_mode;
                     pol_q  <= entry_i.polarity;
                     trig_q <= entry_i.trigger;
                     if (entry_i.mode == DM_EXTERN) begin
                        state_q <= ST_FETCH;
                        req_q   <= 1'b1;
                     end else begin
                        state_q <= ST_SEND;
                     end
                  end
               end
            end
            ST_FETCH: begin
               if (ext_vld_i) begin
                  vec_q   <= ext_vector_i;
                  state_q <= ST_SEND;
               end
            end
            ST_SEND: begin
               if (accept) begin
                  if (burst_done) state_q <= ST_IDLE;
                  else            rem_q   <= rem_nxt;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign msg_valid_o     = (state_q == ST_SEND);
   assign msg_dest_o      = dm_q ? {{(DEST_W-LIDX_W){1'b0}}, low_idx} : dest_q;
   assign msg_vector_o    = vec_q;
   assign msg_mode_o      = mode_q;
   assign msg_dest_mode_o = dm_q;
   assign msg_level_o     = pol_q;
   assign msg_trigger_o   = trig_q;
   assign ext_req_o       = req_q;
   assign err_o           = err_q;

   // R10: a stalled message keeps every field
   a_r10_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_dest_o) &&
      $stable(msg_vector_o) && $stable(msg_mode_o) && $stable(msg_dest_mode_o) &&
      $stable(msg_level_o) && $stable(msg_trigger_o));
   // R4: the vector request is a single-cycle pulse
   a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req_o |=> !ext_req_o);
   // R4: no message before the external vector arrives
   a_r4_wait_vector: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_FETCH && !ext_vld_i |=> !msg_valid_o);
   // R5: an error pulse never coincides with a message
   a_r5_err_no_msg: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !msg_valid_o);
   // R5: the error indication lasts one cycle
   a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o);
   // R7: each accepted burst message retires exactly one bitmap bit
   a_r7_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
      accept && dm_q && !burst_done |=>
      $countones(rem_q) == $past($countones(rem_q)) - 1);
endmodule

// File: rtl/irq_redirect_dispatch.sv
module irq_redirect_dispatch
   import irqd_pkg::*;
#(
   parameter int NUM_LINES = 8,
   localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_LINES-1:0]         irq_lines_i,
   input  logic [NUM_LINES*ENTRY_W-1:0] table_i,
   input  logic                         msg_ready_i,
   input  logic                         ext_vld_i,
   input  logic [VEC_W-1:0]             ext_vector_i,
   output logic                         msg_valid_o,
   output logic [DEST_W-1:0]            msg_dest_o,
   output logic [VEC_W-1:0]             msg_vector_o,
   output logic [MODE_W-1:0]            msg_mode_o,
   output logic                         msg_dest_mode_o,
   output logic                         msg_level_o,
   output logic                         msg_trigger_o,
   output logic                         ext_req_o,
   output logic                         err_o
);
   if (NUM_LINES < 1 || NUM_LINES > 64) begin : g_bad_lines
      $error("irq_redirect_dispatch: NUM_LINES must be 1..64");
   end
   if (DEST_W != 8) begin : g_bad_dest
      $error("irq_redirect_dispatch: destination bitmap must be 8 bits");
   end

   logic [NUM_LINES-1:0] pend, clear;
   logic                 any;
   logic [IDX_W-1:0]     idx;
   redir_t               ent_arr [NUM_LINES];
   redir_t               entry_sel;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_unpack
      assign ent_arr[g] = redir_t'(table_i[g*ENTRY_W +: ENTRY_W]);
   end
   assign entry_sel = ent_arr[idx];

   irqd_pending #(.NUM_LINES(NUM_LINES)) pend_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines_i (irq_lines_i),
      .clear_i (clear),
      .pend_o  (pend)
   );

   irqd_pick #(.NUM_LINES(NUM_LINES)) pick_i (
      .req_i (pend),
      .any_o (any),
      .idx_o (idx)
   );

   irqd_dispatch #(.NUM_LINES(NUM_LINES)) disp_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .any_i           (any),
      .idx_i           (idx),
      .entry_i         (entry_sel),
      .msg_ready_i     (msg_ready_i),
      .ext_vld_i       (ext_vld_i),
      .ext_vector_i    (ext_vector_i),
      .clear_o         (clear),
      .msg_valid_o     (msg_valid_o),
      .msg_dest_o      (msg_dest_o),
      .msg_vector_o    (msg_vector_o),
      .msg_mode_o      (msg_mode_o),
      .msg_dest_mode_o (msg_dest_mode_o),
      .msg_level_o     (msg_level_o),
      .msg_trigger_o   (msg_trigger_o),
      .ext_req_o       (ext_req_o),
      .err_o           (err_o)
   );

   // R9: at most one line is retired per cycle
   a_r9_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clear));
   // R9: only a pending line can be retired
   a_r9_clear_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (clear & ~pend) == '0);
endmodule

// File: tb/irq_redirect_dispatch_tb_top.sv
module irq_redirect_dispatch_tb_top;
   import irqd_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NL = 8;
   localparam int EW = ENTRY_W;
   localparam int NCASE = 12;

   // entry = {dest, mask, trigger, polarity, dest_mode, mode, vector}
   localparam logic [EW-1:0] CASE_ENT [NCASE] = '{
      {8'h05, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 8'h31},  // R6 physical fixed
      {8'hA2, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 8'h40},  // R6 physical NMI
      {8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 8'h55},  // R7 sparse bitmap
      {8'h80, 1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 8'h66},  // R7 top bit only
      {8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 8'h77},  // R7 full bitmap
      {8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 8'h88},  // R11 empty bitmap
      {8'h05, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 8'h99},  // R1 masked
      {8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 8'hAA},  // R5 reserved 3
      {8'h02, 1'b0, 1'b1, 1'b0, 1'b1, 3'd6, 8'hAB},  // R5 reserved 6
      {8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 3'd6, 8'hAC},  // R1 masked beats reserved
      {8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 3'd7, 8'h11},  // R4 external physical
      {8'h06, 1'b0, 1'b0, 1'b1, 1'b1, 3'd7, 8'h12}   // R4 external logical
   };
   localparam logic [7:0] CASE_XV [NCASE] = '{
      8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
      8'h00, 8'h00, 8'h00, 8'h00, 8'h9C, 8'hE3
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NL-1:0]     irq = '0;
   logic [NL*EW-1:0]  tbl;
   logic              rdy = 1'b1;
   logic              ext_vld = 1'b0;
   logic [7:0]        ext_vec = '0;
   logic              msg_valid;
   logic [7:0]        msg_dest, msg_vector;
   logic [2:0]        msg_mode;
   logic              msg_dm, msg_level, msg_trig, ext_req, err;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_redirect_dispatch #(.NUM_LINES(NL)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_lines_i(irq), .table_i(tbl),
      .msg_ready_i(rdy), .ext_vld_i(ext_vld), .ext_vector_i(ext_vec),
      .msg_valid_o(msg_valid), .msg_dest_o(msg_dest), .msg_vector_o(msg_vector),
      .msg_mode_o(msg_mode), .msg_dest_mode_o(msg_dm), .msg_level_o(msg_level),
      .msg_trigger_o(msg_trig), .ext_req_o(ext_req), .err_o(err)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [EW-1:0] masked_entry();
      return {8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00};
   endfunction

   task automatic run_case(input int line, input logic [EW-1:0] ent, input logic [7:0] xv);
      logic [7:0] e_dest, e_vec;
      logic [2:0] e_mode;
      logic       e_mask, e_trig, e_pol, e_dm;
      int         expd [8];
      int         ne = 0, got = 0, errs = 0, exp_err = 0, dly = -1;
      logic [7:0] evec;
      {e_dest, e_mask, e_trig, e_pol, e_dm, e_mode, e_vec} = ent;
      if (e_mask) ne = 0;
      else if (e_mode == 3'd3 || e_mode == 3'd6) exp_err = 1;
      else if (e_dm) begin
         for (int b = 0; b < 8; b++) if (e_dest[b]) begin expd[ne] = b; ne++; end
      end else begin expd[0] = int'(e_dest); ne = 1; end
      evec = (e_mode == 3'd7) ? xv : e_vec;
      tbl[line*EW +: EW] = ent;
      rdy = 1'b1;
      @(negedge clk);
      irq[line] = 1'b1;
      repeat (40) begin
         @(negedge clk);
         ext_vld = 1'b0;
         if (dly == 0) begin ext_vld = 1'b1; ext_vec = xv; dly = -1; end
         else if (dly > 0) dly--;
         if (ext_req) dly = 1;
         if (err) errs++;
         if (msg_valid) begin
            if (got < ne) begin
               chk(e_dm ? "R7" : "R6", "dest", msg_dest, expd[got]);
               chk((e_mode == 3'd7) ? "R4" : "R3", "vector", msg_vector, evec);
               chk("R2", "mode", msg_mode, e_mode);
               chk("R2", "dest mode", msg_dm, e_dm);
               chk("R2", "level", msg_level, e_pol);
               chk("R2", "trigger", msg_trig, e_trig);
            end
            got++;
         end
      end
      irq[line] = 1'b0;
      ext_vld = 1'b0;
      chk(e_mask ? "R1" : (exp_err != 0) ? "R5" : (e_dm && e_dest == 0) ? "R11" : "R7",
          "message count", got, ne);
      chk(exp_err != 0 ? "R5" : "R1", "error pulses", errs, exp_err);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int got;
      logic [7:0] seen [4];
      for (int l = 0; l < NL; l++) tbl[l*EW +: EW] = masked_entry();

      // R12 reset state
      repeat (3) @(negedge clk);
      chk("R12", "valid in reset", msg_valid, 1'b0);
      chk("R12", "ext_req in reset", ext_req, 1'b0);
      chk("R12", "err in reset", err, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int c = 0; c < NCASE; c++) run_case(0, CASE_ENT[c], CASE_XV[c]);

      // R10 stall in the middle of a logical burst
      tbl[1*EW +: EW] = {8'h03, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 8'h22};
      rdy = 1'b0;
      @(negedge clk); irq[1] = 1'b1;
      repeat (5) @(negedge clk);
      chk("R10", "valid while stalled", msg_valid, 1'b1);
      chk("R10", "first dest", msg_dest, 8'd0);
      repeat (3) @(negedge clk);
      chk("R10", "dest held", msg_dest, 8'd0);
      chk("R10", "vector held", msg_vector, 8'h22);
      rdy = 1'b1;
      @(negedge clk);
      rdy = 1'b0;
      chk("R10", "advanced after accept", msg_dest, 8'd1);
      repeat (2) @(negedge clk);
      chk("R10", "second dest held", msg_dest, 8'd1);
      chk("R10", "second valid held", msg_valid, 1'b1);
      rdy = 1'b1;
      @(negedge clk);
      chk("R10", "burst ends after last accept", msg_valid, 1'b0);
      irq[1] = 1'b0;

      // R9 simultaneous lines, R8 level held
      tbl[2*EW +: EW] = {8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'hA2};
      tbl[5*EW +: EW] = {8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'hA5};
      @(negedge clk); irq[2] = 1'b1; irq[5] = 1'b1;
      got = 0;
      repeat (30) begin
         @(negedge clk);
         if (msg_valid) begin if (got < 4) seen[got] = msg_vector; got++; end
      end
      chk("R8", "messages with lines held high", got, 2);
      chk("R9", "lowest line first", seen[0], 8'hA2);
      chk("R9", "higher line second", seen[1], 8'hA5);
      irq[5] = 1'b0;
      @(negedge clk); irq[5] = 1'b1;
      got = 0;
      repeat (10) begin
         @(negedge clk);
         if (msg_valid) begin if (got < 4) seen[got] = msg_vector; got++; end
      end
      chk("R8", "new edge serves again", got, 1);
      chk("R8", "re-served vector", seen[0], 8'hA5);
      irq[2] = 1'b0; irq[5] = 1'b0;

      // R1 masked event is consumed
      tbl[3*EW +: EW] = {8'h04, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'hB3};
      @(negedge clk); irq[3] = 1'b1;
      repeat (6) @(negedge clk);
      tbl[3*EW +: EW] = {8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'hB3};
      got = 0;
      repeat (10) begin
         @(negedge clk);
         if (msg_valid) got++;
      end
      chk("R1", "no message after unmask", got, 0);
      irq[3] = 1'b0;
      @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule